// File: doc/BRIEF.md
# Aggregating Interrupt Controller with Per-Source Trigger Selection

This block gathers ten peripheral interrupt lines into a single active-low request for a host processor whose interrupt pin reacts to a falling edge. Each line is first brought into the block's clock domain. It is then qualified by its own 3-bit trigger code, which selects one of five detection modes: two single edges, both edges, or one of two levels. A qualified event sets a pending bit. The host clears a pending bit by writing a word with a zero in that bit position; ones elsewhere in the word leave the other bits alone. A mask register gates pending bits from the combined request.

The host reaches the block through a flat 16-bit register port with a 3-bit address, a write strobe and a read path that has no wait states. Besides the interrupt registers, the port exposes a read-only identity word and a small register whose bits drive peripheral reset lines. The request pin is the inverse OR of all pending, unmasked sources. Its edge-sensitive consumer is told about work still outstanding when the host briefly masks everything and then puts the mask back.

Top module: `irq_aggregator`

## Requirements
- R1: After synchronous reset: pending bits are 0, the mask reads 0xFFFF, both trigger registers read 0, the peripheral reset register reads 0 and `irq_n` is 1.
- R2: The trigger code of source n (n<5) sits at address 2, bits 3n+2..3n. For n>=5 it sits at address 3, bits 3(n-5)+2..3(n-5). Both registers read back what was written, and bit 15 reads 0.
- R3: Code 1 latches a pending bit on a falling edge of the synchronised input, code 2 on a rising edge and code 3 on either edge. The opposite edge of a single-edge code sets nothing.
- R4: Code 4 (low) and code 5 (high) make the pending bit equal to "level active". Writing 0 cannot clear the bit while the level is active, and the bit drops by itself once the level goes away.
- R5: Code 0 and the reserved codes 6 and 7 set no pending bit on any input change.
- R6: Pending register at address 0, bit n = source n. A write clears each edge-latched bit whose written value is 0 and keeps each bit written as 1. Bits 15..10 read 0.
- R7: Mask at address 1 is a 16-bit read/write register. A 1 in bit n keeps source n off the request.
- R8: `irq_n` is registered: it is 0 one cycle after any source is both pending and unmasked, and 1 otherwise. Writing 0xFFFF to the mask and then restoring it raises `irq_n` and then lowers it again while a source is pending.
- R9: Address 4 reads {BOARD_ID, LOGIC_VER} (board number in bits 15:8, version in 7:0). Writes there change nothing.
- R10: Address 5 holds NUM_PERIPH read/write bits that drive `periph_rst` directly. The upper bits read 0.
- R11: Addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | NUM_SRC | Asynchronous peripheral interrupt lines |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, no wait state |
| irq_n | output | 1 | Combined active-low request |
| periph_rst | output | NUM_PERIPH | Peripheral reset lines |

## Verification
The bench builds the block with its default parameters: ten sources packed five per control register, eight reset lines and fixed identity bytes. With ten sources, both control registers are in use, so source 9 lands in the top field of the high register and the field-placement rule is tested across the register boundary. A table drives every trigger code, including the reserved ones, through both input transitions on a different source. Directed cases then cover the zero-to-clear rule, a level that resists clearing, and the mask-and-restore pulse on the request pin.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int DATA_W   = 16;
    localparam int ADDR_W   = 3;
    localparam int TRIG_W   = 3;

    typedef enum logic [TRIG_W-1:0] {
        TRIG_OFF  = 3'd0,
        TRIG_FALL = 3'd1,
        TRIG_RISE = 3'd2,
        TRIG_BOTH = 3'd3,
        TRIG_LOW  = 3'd4,
        TRIG_HIGH = 3'd5,
        TRIG_RSV6 = 3'd6,
        TRIG_RSV7 = 3'd7
    } trig_e;

    typedef enum logic [ADDR_W-1:0] {
        RA_PEND   = 3'd0,
        RA_MASK   = 3'd1,
        RA_TRIGLO = 3'd2,
        RA_TRIGHI = 3'd3,
        RA_IDENT  = 3'd4,
        RA_PRST   = 3'd5,
        RA_NONE6  = 3'd6,
        RA_NONE7  = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic edge_hit;
        logic level_on;
        logic level_mode;
    } det_t;

    function automatic det_t classify(logic [TRIG_W-1:0] code, logic cur, logic prev);
        det_t d;
        d = '0;
        case (trig_e'(code))
            TRIG_FALL: d.edge_hit = prev & ~cur;
            TRIG_RISE: d.edge_hit = ~prev & cur;
            TRIG_BOTH: d.edge_hit = prev ^ cur;
            TRIG_LOW: begin
                d.level_mode = 1'b1;
                d.level_on   = ~cur;
            end
            TRIG_HIGH: begin
                d.level_mode = 1'b1;
                d.level_on   = cur;
            end
            default: d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int WIDTH  = 10,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] prev
);
    logic [WIDTH-1:0] pipe [STAGES];
    logic [WIDTH-1:0] last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) pipe[s] <= '0;
            last_q <= '0;
        end else begin
            pipe[0] <= raw;
            for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
            last_q <= pipe[STAGES-1];
        end
    end

    assign cur  = pipe[STAGES-1];
    assign prev = last_q;
endmodule

// File: rtl/irq_detect.sv
module irq_detect
    import irq_agg_pkg::*;
#(
    parameter int NUM_SRC = 10
) (
    input  logic [NUM_SRC-1:0]        cur,
    input  logic [NUM_SRC-1:0]        prev,
    input  logic [NUM_SRC*TRIG_W-1:0] modes,
    output logic [NUM_SRC-1:0]        evt,
    output logic [NUM_SRC-1:0]        lvl,
    output logic [NUM_SRC-1:0]        lvl_mode
);
    for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
        det_t d;
        always_comb d = classify(modes[n*TRIG_W +: TRIG_W], cur[n], prev[n]);
        assign evt[n]      = d.edge_hit;
        assign lvl[n]      = d.level_on;
        assign lvl_mode[n] = d.level_mode;
    end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import irq_agg_pkg::*;
#(
    parameter int          NUM_SRC      = 10,
    parameter int          SRCS_PER_REG = 5,
    parameter int          NUM_PERIPH   = 8,
    parameter logic [7:0]  BOARD_ID     = 8'h2A,
    parameter logic [7:0]  LOGIC_VER    = 8'h07
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [ADDR_W-1:0]         addr,
    input  logic                      we,
    input  logic [DATA_W-1:0]         wdata,
    input  logic [NUM_SRC-1:0]        evt,
    input  logic [NUM_SRC-1:0]        lvl,
    input  logic [NUM_SRC-1:0]        lvl_mode,
    output logic [DATA_W-1:0]         rdata,
    output logic [NUM_SRC-1:0]        pend,
    output logic [DATA_W-1:0]         mask,
    output logic [NUM_SRC*TRIG_W-1:0] modes,
    output logic [NUM_PERIPH-1:0]     prst
);
    localparam int FIELD_BITS = SRCS_PER_REG * TRIG_W;
    localparam logic [DATA_W-1:0] FIELD_MASK = DATA_W'((1 << FIELD_BITS) - 1);

    logic [DATA_W-1:0]     trig_q [2];
    logic [DATA_W-1:0]     mask_q;
    logic [NUM_SRC-1:0]    pend_q;
    logic [NUM_PERIPH-1:0] prst_q;
    reg_addr_e             ra;

    assign ra = reg_addr_e'(addr);

    wire wr_pend = we && (ra == RA_PEND);

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q[0] <= '0;
            trig_q[1] <= '0;
            mask_q    <= '1;
            prst_q    <= '0;
        end else if (we) begin
            case (ra)
                RA_MASK:   mask_q    <= wdata;
                RA_TRIGLO: trig_q[0] <= wdata & FIELD_MASK;
                RA_TRIGHI: trig_q[1] <= wdata & FIELD_MASK;
                RA_PRST:   prst_q    <= wdata[NUM_PERIPH-1:0];
                default: ;
            endcase
        end
    end

    for (genvar n = 0; n < NUM_SRC; n++) begin : g_pend
        localparam int BANK = n / SRCS_PER_REG;
        localparam int POS  = (n % SRCS_PER_REG) * TRIG_W;
        assign modes[n*TRIG_W +: TRIG_W] = trig_q[BANK][POS +: TRIG_W];

        logic keep;
        assign keep = !(wr_pend && !wdata[n]);

        always_ff @(posedge clk) begin
            if (rst)              pend_q[n] <= 1'b0;
            else if (lvl_mode[n]) pend_q[n] <= lvl[n];
            else                  pend_q[n] <= evt[n] | (pend_q[n] & keep);
        end
    end

    always_comb begin
        case (ra)
            RA_PEND:   rdata = DATA_W'(pend_q);
            RA_MASK:   rdata = mask_q;
            RA_TRIGLO: rdata = trig_q[0];
            RA_TRIGHI: rdata = trig_q[1];
            RA_IDENT:  rdata = {BOARD_ID, LOGIC_VER};
            RA_PRST:   rdata = DATA_W'(prst_q);
            default:   rdata = '0;
        endcase
    end

    assign pend = pend_q;
    assign mask = mask_q;
    assign prst = prst_q;
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int         NUM_SRC      = 10,
    parameter int         SRCS_PER_REG = 5,
    parameter int         NUM_PERIPH   = 8,
    parameter int         SYNC_STAGES  = 2,
    parameter logic [7:0] BOARD_ID     = 8'h2A,
    parameter logic [7:0] LOGIC_VER    = 8'h07
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_SRC-1:0]    src_in,
    input  logic [2:0]            bus_addr,
    input  logic                  bus_we,
    input  logic [15:0]           bus_wdata,
    output logic [15:0]           bus_rdata,
    output logic                  irq_n,
    output logic [NUM_PERIPH-1:0] periph_rst
);
    logic [NUM_SRC-1:0]        s_cur, s_prev;
    logic [NUM_SRC-1:0]        evt_vec, lvl_vec, lvl_mode_vec;
    logic [NUM_SRC-1:0]        status_vec;
    logic [DATA_W-1:0]         mask_vec;
    logic [NUM_SRC*TRIG_W-1:0] mode_vec;
    logic                      irq_n_q;

    irq_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .raw(src_in), .cur(s_cur), .prev(s_prev)
    );

    irq_detect #(.NUM_SRC(NUM_SRC)) u_det (
        .cur(s_cur), .prev(s_prev), .modes(mode_vec),
        .evt(evt_vec), .lvl(lvl_vec), .lvl_mode(lvl_mode_vec)
    );

    irq_regs #(
        .NUM_SRC(NUM_SRC), .SRCS_PER_REG(SRCS_PER_REG), .NUM_PERIPH(NUM_PERIPH),
        .BOARD_ID(BOARD_ID), .LOGIC_VER(LOGIC_VER)
    ) u_regs (
        .clk(clk), .rst(rst), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
        .evt(evt_vec), .lvl(lvl_vec), .lvl_mode(lvl_mode_vec),
        .rdata(bus_rdata), .pend(status_vec), .mask(mask_vec),
        .modes(mode_vec), .prst(periph_rst)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_n_q <= 1'b1;
        else     irq_n_q <= ~|(status_vec & ~mask_vec[NUM_SRC-1:0]);
    end

    assign irq_n = irq_n_q;
endmodule

// File: rtl/irq_agg_checker.sv
module irq_agg_checker #(
    parameter int NUM_SRC    = 10,
    parameter int NUM_PERIPH = 8
) (
    input logic                  clk,
    input logic                  rst,
    input logic [2:0]            bus_addr,
    input logic                  bus_we,
    input logic [15:0]           bus_wdata,
    input logic [15:0]           bus_rdata,
    input logic                  irq_n,
    input logic [NUM_PERIPH-1:0] periph_rst,
    input logic [NUM_SRC-1:0]    status_vec,
    input logic [15:0]           mask_vec,
    input logic [NUM_SRC-1:0]    evt_vec,
    input logic [NUM_SRC-1:0]    lvl_vec
);
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (mask_vec == 16'hFFFF && status_vec == '0 && irq_n));

    a_r8_request_follows: assert property (@(posedge clk) disable iff (rst)
        irq_n == !$past(|(status_vec & ~mask_vec[NUM_SRC-1:0])));

    a_r4_level_sticks: assert property (@(posedge clk) disable iff (rst)
        (status_vec & $past(lvl_vec)) == $past(lvl_vec));

    a_r6_zero_clears: assert property (@(posedge clk) disable iff (rst)
        $past(bus_we && bus_addr == 3'd0) |->
        (status_vec & ~($past(bus_wdata[NUM_SRC-1:0]) | $past(evt_vec) | $past(lvl_vec))) == '0);

    a_r6_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 3'd0) |-> (bus_rdata[15:NUM_SRC] == '0));

    a_r7_mask_write: assert property (@(posedge clk) disable iff (rst)
        $past(bus_we && bus_addr == 3'd1) |-> (mask_vec == $past(bus_wdata)));

    a_r10_prst_write: assert property (@(posedge clk) disable iff (rst)
        $past(bus_we && bus_addr == 3'd5) |-> (periph_rst == $past(bus_wdata[NUM_PERIPH-1:0])));

    a_r11_hole_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr > 3'd5) |-> (bus_rdata == 16'h0000));
endmodule

bind irq_aggregator irq_agg_checker #(.NUM_SRC(NUM_SRC), .NUM_PERIPH(NUM_PERIPH)) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n),
    .periph_rst(periph_rst), .status_vec(status_vec), .mask_vec(mask_vec),
    .evt_vec(evt_vec), .lvl_vec(lvl_vec)
);

// File: tb/irq_aggregator_test.sv
module irq_aggregator_test;
    localparam int NSRC = 10;
    localparam int NPER = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NSRC-1:0] src_in = '0;
    logic [2:0]      bus_addr = '0;
    logic            bus_we = 1'b0;
    logic [15:0]     bus_wdata = '0;
    logic [15:0]     bus_rdata;
    logic            irq_n;
    logic [NPER-1:0] periph_rst;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [15:0] trig_sh [2];

    always #5 clk = ~clk;

    irq_aggregator uut (
        .clk(clk), .rst(rst), .src_in(src_in), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_n(irq_n), .periph_rst(periph_rst)
    );

    typedef struct packed {
        logic [3:0] src;
        logic [2:0] code;
        logic       init;
        logic       fin;
        logic       exp;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{4'd0, 3'd1, 1'b1, 1'b0, 1'b1},
        '{4'd1, 3'd1, 1'b0, 1'b1, 1'b0},
        '{4'd2, 3'd2, 1'b0, 1'b1, 1'b1},
        '{4'd3, 3'd2, 1'b1, 1'b0, 1'b0},
        '{4'd4, 3'd3, 1'b1, 1'b0, 1'b1},
        '{4'd5, 3'd3, 1'b0, 1'b1, 1'b1},
        '{4'd6, 3'd4, 1'b1, 1'b0, 1'b1},
        '{4'd7, 3'd5, 1'b0, 1'b1, 1'b1},
        '{4'd8, 3'd5, 1'b1, 1'b0, 1'b0},
        '{4'd9, 3'd0, 1'b0, 1'b1, 1'b0},
        '{4'd9, 3'd6, 1'b1, 1'b0, 1'b0},
        '{4'd9, 3'd7, 1'b0, 1'b1, 1'b0}
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic set_code(input int n, input logic [2:0] code);
        if (n < 5) begin
            trig_sh[0][3*n +: 3] = code;
            wr(3'd2, trig_sh[0]);
        end else begin
            trig_sh[1][3*(n-5) +: 3] = code;
            wr(3'd3, trig_sh[1]);
        end
    endtask

    initial begin : watchdog
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] d;
        trig_sh[0] = '0;
        trig_sh[1] = '0;
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(1);

        // R1 reset state
        rd(3'd0, d); check("R1 pending", d, 16'h0000);
        rd(3'd1, d); check("R1 mask", d, 16'hFFFF);
        rd(3'd2, d); check("R1 trig lo", d, 16'h0000);
        rd(3'd3, d); check("R1 trig hi", d, 16'h0000);
        rd(3'd5, d); check("R1 prst", d, 16'h0000);
        check("R1 irq_n", {15'h0, irq_n}, 16'h0001);

        // R3 R4 R5 table of trigger behaviour
        for (int v = 0; v < NV; v++) begin
            int s;
            s = int'(VECS[v].src);
            src_in[s] = VECS[v].init;
            wait_cyc(4);
            set_code(s, VECS[v].code);
            wait_cyc(4);
            wr(3'd0, 16'h0000);
            src_in[s] = VECS[v].fin;
            wait_cyc(6);
            rd(3'd0, d);
            check($sformatf("R3/R4/R5 vec%0d src%0d code%0d", v, s, VECS[v].code),
                  {15'h0, d[s]}, {15'h0, VECS[v].exp});
            set_code(s, 3'd0);
            wr(3'd0, 16'h0000);
            src_in[s] = 1'b0;
            wait_cyc(4);
        end
        wr(3'd0, 16'h0000);

        // R2 field placement across both registers
        set_code(9, 3'd5);
        set_code(0, 3'd6);
        rd(3'd3, d); check("R2 hi field src9", d, 16'h5000);
        rd(3'd2, d); check("R2 lo field src0", d, 16'h0006);
        wr(3'd2, 16'hFFFF);
        rd(3'd2, d); check("R2 bit15 reads 0", d, 16'h7FFF);
        trig_sh[0] = 16'h0000; wr(3'd2, 16'h0000);
        set_code(9, 3'd0);

        // R6 clear by zero, keep by one
        set_code(2, 3'd2);
        src_in[2] = 1'b1;
        wait_cyc(6);
        wr(3'd0, 16'hFFFF);
        rd(3'd0, d); check("R6 ones keep", d, 16'h0004);
        wr(3'd0, 16'hFFFB);
        rd(3'd0, d); check("R6 zero clears", d, 16'h0000);

        // R7 R8 masking and refresh pulse
        src_in[2] = 1'b0; wait_cyc(4);
        src_in[2] = 1'b1; wait_cyc(6);
        check("R7 masked irq_n high", {15'h0, irq_n}, 16'h0001);
        wr(3'd1, 16'hFFFB);
        rd(3'd1, d); check("R7 mask readback", d, 16'hFFFB);
        wait_cyc(1);
        check("R8 irq_n low", {15'h0, irq_n}, 16'h0000);
        wr(3'd1, 16'hFFFF);
        wait_cyc(1);
        check("R8 pulse high", {15'h0, irq_n}, 16'h0001);
        wr(3'd1, 16'hFFFB);
        wait_cyc(1);
        check("R8 pulse relow", {15'h0, irq_n}, 16'h0000);
        wr(3'd0, 16'hFFFB);
        wait_cyc(2);
        check("R8 clear raises irq_n", {15'h0, irq_n}, 16'h0001);
        wr(3'd1, 16'hFFFF);
        set_code(2, 3'd0);

        // R4 level cannot be cleared while asserted
        src_in[7] = 1'b1;
        set_code(7, 3'd5);
        wait_cyc(5);
        wr(3'd0, 16'h0000);
        rd(3'd0, d); check("R4 level resists clear", {15'h0, d[7]}, 16'h0001);
        src_in[7] = 1'b0;
        wait_cyc(5);
        rd(3'd0, d); check("R4 level drops", {15'h0, d[7]}, 16'h0000);
        set_code(7, 3'd0);

        // R9 identity read-only
        rd(3'd4, d); check("R9 ident", d, 16'h2A07);
        wr(3'd4, 16'h1234);
        rd(3'd4, d); check("R9 ident unchanged", d, 16'h2A07);

        // R10 peripheral reset register
        wr(3'd5, 16'hFFA5);
        rd(3'd5, d); check("R10 prst readback", d, 16'h00A5);
        check("R10 prst pins", {8'h0, periph_rst}, 16'h00A5);

        // R11 unmapped addresses
        rd(3'd6, d); check("R11 addr6", d, 16'h0000);
        rd(3'd7, d); check("R11 addr7", d, 16'h0000);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule